// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block decides, from the 48-bit destination address at the head of an incoming Ethernet frame, whether the receive path should keep the frame. Address bytes arrive one per cycle on a byte stream. A start strobe marks the first byte, and cycles without the valid flag are stalls. While the bytes arrive, the block shifts them into an address register and folds them into a running CRC-32. In the cycle after the sixth byte it gives one accept or reject verdict with a one-cycle valid pulse.

There are four ways a frame can be accepted:
- a unicast address that exactly matches the programmed station address;
- a group (multicast) address whose CRC-derived index hits a 64-bit hash table;
- the all-ones broadcast address, when broadcast reception is enabled;
- any frame at all, when the filter is in promiscuous mode.

An all-multicast mode treats the whole hash table as set. Software programs the station address, the hash table and the mode flags through a simple write port: a write strobe, a register select and 32 data bits.

Control is a three-state machine:
- **ST_IDLE** waits for a start strobe.
- **ST_COLLECT** gathers the remaining address bytes. A new start strobe restarts the count.
- **ST_DECIDE** lasts one cycle and presents the verdict.

The transitions are:
- IDLE→COLLECT on a valid byte with the start strobe.
- COLLECT→COLLECT on stalls, on ordinary bytes before the sixth, and on a restarting start strobe.
- COLLECT→DECIDE on the sixth valid byte that carries no start strobe.
- DECIDE→COLLECT on a start strobe with a valid byte.
- DECIDE→IDLE otherwise.

Top module: `dst_filt`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are low, the station address is all zeros, every hash table bit is clear and all three mode flags are off.
- R2: A byte is taken when `rx_vld` is high. The first byte also needs `rx_sof`. Cycles with `rx_vld` low are stalls. `dec_valid` is high for exactly the one cycle after the clock edge that takes the sixth byte, and is low otherwise.
- R3: A frame whose first byte has bit 0 clear is unicast. It is accepted only when all 48 address bits equal the station address. Select 0 writes `cfg_wdata[23:0]` as address bytes 0,1,2, with byte 0 in bits 23:16. Select 1 writes bytes 3,4,5 the same way. Byte 0 is the first byte received.
- R4: A frame whose first byte has bit 0 set, and that is not all ones, is multicast. It is accepted when hash table bit `idx` is set. To form `idx`:
  - the CRC register starts at 0xFFFFFFFF;
  - for each address byte in arrival order, and within a byte from bit 0 upward, the feedback bit is CRC bit 31 XOR the data bit;
  - the register shifts one place toward its MSB, then XORs 0x04C11DB7 when the feedback bit is 1;
  - there is no final inversion, and `idx` is bits 31:26 of the result.
  Select 2 writes table bits 0–31 and select 3 writes bits 32–63, so `idx` bit 5 picks the word and bits 4:0 pick the bit.
- R5: Select 4 writes the mode flags: bit 0 broadcast enable, bit 1 promiscuous, bit 2 all-multicast. With all-multicast set, every multicast frame is accepted whatever the table holds. Unicast handling is unchanged.
- R6: The all-ones address is accepted only when broadcast enable is set. The hash table and all-multicast have no effect on it.
- R7: With promiscuous set, every frame is accepted.
- R8: A start strobe during collection discards the bytes gathered so far and begins a new address. Valid bytes that arrive after the sixth without a start strobe produce no decision.
- R9: `dec_accept` is low whenever `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sof | input | 1 | Marks the first address byte of a frame |
| rx_vld | input | 1 | Byte on `rx_byte` is valid this cycle |
| rx_byte | input | 8 | Destination address byte, byte 0 first |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0/1 station address, 2/3 hash words, 4 mode flags |
| cfg_wdata | input | 32 | Configuration write data |
| dec_valid | output | 1 | Verdict valid, one cycle per address |
| dec_accept | output | 1 | Frame accepted (valid with `dec_valid`) |

## Verification
Fixed addresses are run against a reference model of the filter, one under each mode-flag combination:
- the exact station address, and station addresses differing in the first or the last byte, separate the full 48-bit compare from a partial one;
- a multicast address whose table bit is set and one whose bit is not separate hash use from blanket acceptance;
- the broadcast address under each flag shows that only broadcast enable governs it.

A group address with hash index 32 or above is tried with its bit placed in the right word and then in the wrong word, which exposes a swapped word select or bit order. Stalled byte streams, a restart in the middle of an address and trailing bytes after the sixth check the collection timing. A run before any configuration checks the reset contents.

// File: rtl/dst_filt_pkg.sv
package dst_filt_pkg;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2
    } state_t;

    // Mode flags, bit order fixed by the configuration encoding.
    typedef struct packed {
        logic allmulti;   // bit 2
        logic promisc;    // bit 1
        logic bcast_en;   // bit 0
    } mode_t;

    // One byte of the hash CRC: data bits enter from bit 0 upward,
    // register shifts toward its MSB.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                   input logic [7:0]       data);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = cur;
        for (int i = 0; i < 8; i++) begin
            fb = c[CRC_W-1] ^ data[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/dst_filt_cfg.sv
module dst_filt_cfg
    import dst_filt_pkg::*;
#(
    parameter int ADDR_W    = 48,
    parameter int WORD_W    = 32,
    parameter int HASH_BITS = 6,
    parameter int SEL_W     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [SEL_W-1:0]           cfg_sel,
    input  logic [WORD_W-1:0]          cfg_wdata,
    output logic [ADDR_W-1:0]          station,
    output logic [(1<<HASH_BITS)-1:0]  hash_tbl,
    output mode_t                      mode
);
    localparam int HALF_W     = ADDR_W / 2;
    localparam int HASH_WORDS = (1 << HASH_BITS) / WORD_W;
    localparam int SEL_HASH0  = 2;
    localparam int SEL_MODE   = SEL_HASH0 + HASH_WORDS;

    logic [ADDR_W-1:0] station_q;
    mode_t             mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            station_q <= '0;
            mode_q    <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_W'(0))
                station_q[ADDR_W-1:HALF_W] <= cfg_wdata[HALF_W-1:0];
            if (cfg_sel == SEL_W'(1))
                station_q[HALF_W-1:0] <= cfg_wdata[HALF_W-1:0];
            if (cfg_sel == SEL_W'(SEL_MODE))
                mode_q <= mode_t'(cfg_wdata[2:0]);
        end
    end

    genvar w;
    generate
        for (w = 0; w < HASH_WORDS; w++) begin : g_hash_word
            logic [WORD_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (cfg_we && cfg_sel == SEL_W'(SEL_HASH0 + w))
                    word_q <= cfg_wdata;
            end
            assign hash_tbl[w*WORD_W +: WORD_W] = word_q;
        end
    endgenerate

    assign station = station_q;
    assign mode    = mode_q;

endmodule

// File: rtl/dst_filt_crc.sv
module dst_filt_crc
    import dst_filt_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 step,
    input  logic [BYTE_W-1:0]    data,
    output logic [HASH_BITS-1:0] idx
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= CRC_INIT;
        else if (start)
            crc_q <= crc_step(CRC_INIT, data);
        else if (step)
            crc_q <= crc_step(crc_q, data);
    end

    assign idx = crc_q[CRC_W-1 -: HASH_BITS];

endmodule

// File: rtl/dst_filt_decide.sv
module dst_filt_decide
    import dst_filt_pkg::*;
#(
    parameter int ADDR_W    = 48,
    parameter int BYTE_W    = 8,
    parameter int HASH_BITS = 6
) (
    input  logic [ADDR_W-1:0]          dst,
    input  logic [ADDR_W-1:0]          station,
    input  logic [(1<<HASH_BITS)-1:0]  hash_tbl,
    input  logic [HASH_BITS-1:0]       idx,
    input  mode_t                      mode,
    output logic                       hit
);
    typedef enum logic [1:0] {
        K_UNICAST = 2'd0,
        K_GROUP   = 2'd1,
        K_BCAST   = 2'd2
    } kind_t;

    kind_t kind;

    always_comb begin
        if (&dst)
            kind = K_BCAST;
        else if (dst[ADDR_W-BYTE_W])
            kind = K_GROUP;
        else
            kind = K_UNICAST;
    end

    always_comb begin
        hit = 1'b0;
        if (mode.promisc) begin
            hit = 1'b1;
        end else begin
            unique case (kind)
                K_BCAST:   hit = mode.bcast_en;
                K_GROUP:   hit = mode.allmulti | hash_tbl[idx];
                K_UNICAST: hit = (dst == station);
                default:   hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dst_filt.sv
module dst_filt
    import dst_filt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int BYTE_W     = 8,
    parameter int HASH_BITS  = 6,
    parameter int WORD_W     = 32,
    parameter int SEL_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam int ADDR_W = ADDR_BYTES * BYTE_W;
    localparam int CNT_W  = $clog2(ADDR_BYTES);

    state_t                    state_q, state_d;
    logic [CNT_W-1:0]          cnt_q;
    logic [ADDR_W-1:0]         dst_q;
    logic [ADDR_W-1:0]         station_q;
    logic [(1<<HASH_BITS)-1:0] hash_tbl;
    mode_t                     mode_q;
    logic [HASH_BITS-1:0]      hash_idx;
    logic                      hit;
    logic                      start, take, last;
    logic                      mode_promisc, mode_bcast;

    assign start = rx_vld & rx_sof;
    assign take  = start | (rx_vld & (state_q == ST_COLLECT));
    assign last  = rx_vld & ~rx_sof & (state_q == ST_COLLECT)
                   & (cnt_q == CNT_W'(ADDR_BYTES - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_COLLECT;
            ST_COLLECT: if (last)  state_d = ST_DECIDE;
            ST_DECIDE:  state_d = start ? ST_COLLECT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Byte counter and address shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dst_q <= '0;
        end else if (take) begin
            cnt_q <= start ? CNT_W'(1) : cnt_q + CNT_W'(1);
            dst_q <= {dst_q[ADDR_W-BYTE_W-1:0], rx_byte};
        end
    end

    // Outputs
    always_comb begin
        dec_valid  = (state_q == ST_DECIDE);
        dec_accept = dec_valid & hit;
    end

    dst_filt_cfg #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .HASH_BITS(HASH_BITS), .SEL_W(SEL_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .station(station_q), .hash_tbl(hash_tbl),
        .mode(mode_q)
    );

    dst_filt_crc #(
        .BYTE_W(BYTE_W), .HASH_BITS(HASH_BITS)
    ) u_crc (
        .clk(clk), .rst_n(rst_n), .start(start),
        .step(take & ~start), .data(rx_byte), .idx(hash_idx)
    );

    dst_filt_decide #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .HASH_BITS(HASH_BITS)
    ) u_dec (
        .dst(dst_q), .station(station_q), .hash_tbl(hash_tbl),
        .idx(hash_idx), .mode(mode_q), .hit(hit)
    );

    assign mode_promisc = mode_q.promisc;
    assign mode_bcast   = mode_q.bcast_en;

endmodule

// File: rtl/dst_filt_chk.sv
module dst_filt_chk #(
    parameter int ADDR_W = 48,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_vld,
    input logic              dec_valid,
    input logic              dec_accept,
    input logic [ADDR_W-1:0] dst,
    input logic [ADDR_W-1:0] station,
    input logic              promisc,
    input logic              bcast_en
);
    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R2
    byte_before_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_vld));

    // R7
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && promisc) |-> dec_accept);

    // R6
    bcast_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (&dst) && !promisc && !bcast_en) |-> !dec_accept);

    // R3
    ucast_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dst[ADDR_W-BYTE_W] && dst != station && !promisc) |-> !dec_accept);

endmodule

bind dst_filt dst_filt_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dst(dst_q), .station(station_q),
    .promisc(mode_promisc), .bcast_en(mode_bcast)
);

// File: tb/tb_dst_filt.sv
module tb_dst_filt;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0, rx_vld = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        dec_valid, dec_accept;

    int n_chk = 0, n_fail = 0;
    logic        done = 1'b0;

    // bench-side copy of what was programmed
    logic [47:0] m_station = '0;
    logic [63:0] m_hash = '0;
    logic [2:0]  m_mode = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dst_filt dut (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_vld(rx_vld),
        .rx_byte(rx_byte), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] GRP_A = 48'h01_00_5E_00_00_FB;
    localparam logic [47:0] GRP_B = 48'h01_00_5E_12_34_56;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] OTHER = 48'h00_AA_BB_CC_DD_EE;

    // {mode[2:0], address}; expected verdict comes from the reference model
    localparam logic [50:0] VEC [13] = '{
        {3'b000, STA},
        {3'b000, 48'h02_11_22_33_44_54},
        {3'b000, 48'h06_11_22_33_44_55},
        {3'b000, GRP_A},
        {3'b000, GRP_B},
        {3'b000, BCAST},
        {3'b001, BCAST},
        {3'b100, GRP_B},
        {3'b100, BCAST},
        {3'b100, OTHER},
        {3'b010, OTHER},
        {3'b010, BCAST},
        {3'b010, GRP_B}
    };

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] r;
        logic        fb;
        r = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int b = 0; b < 8; b++) begin
                fb = r[31] ^ a[47 - 8*k - 7 + b];
                r  = r << 1;
                if (fb) r = r ^ 32'h04C1_1DB7;
            end
        end
        return r[31:26];
    endfunction

    function automatic logic ref_accept(input logic [47:0] a);
        if (m_mode[1]) return 1'b1;
        if (a == BCAST) return m_mode[0];
        if (a[40]) return m_mode[2] | m_hash[ref_idx(a)];
        return a == m_station;
    endfunction

    task automatic check(input logic ok, input string req, input logic act, input logic exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            3'd0: m_station[47:24] = d[23:0];
            3'd1: m_station[23:0]  = d[23:0];
            3'd2: m_hash[31:0]     = d;
            3'd3: m_hash[63:32]    = d;
            3'd4: m_mode           = d[2:0];
            default: ;
        endcase
    endtask

    // Sends an address; with stall set, inserts an idle cycle after each byte.
    task automatic run_frame(input logic [47:0] a, input logic stall, input string req);
        logic exp;
        exp = ref_accept(a);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = a[47 - 8*i -: 8];
            if (stall && i < 5) begin
                @(negedge clk);
                rx_vld = 1'b0; rx_sof = 1'b0;
                check(dec_valid == 1'b0, "R2 stall", dec_valid, 1'b0);
            end
        end
        @(negedge clk);
        rx_vld = 1'b0; rx_sof = 1'b0;
        check(dec_valid == 1'b1, {req, " valid"}, dec_valid, 1'b1);
        check(dec_accept == exp, req, dec_accept, exp);
        @(negedge clk);
        check(dec_valid == 1'b0, "R2 one-cycle", dec_valid, 1'b0);
        check(dec_accept == 1'b0, "R9 quiet", dec_accept, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] g;
        logic [5:0]  gi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(dec_valid == 1'b0, "R1 valid", dec_valid, 1'b0);
        check(dec_accept == 1'b0, "R1 accept", dec_accept, 1'b0);
        run_frame(48'h0, 1'b0, "R1 station zero");
        run_frame(BCAST, 1'b0, "R1 bcast off");
        run_frame(GRP_A, 1'b0, "R1 hash clear");

        // configuration
        cfg_write(3'd0, {8'h0, STA[47:24]});
        cfg_write(3'd1, {8'h0, STA[23:0]});
        gi = ref_idx(GRP_A);
        if (gi[5]) cfg_write(3'd3, 32'h1 << gi[4:0]);
        else       cfg_write(3'd2, 32'h1 << gi[4:0]);

        // vector table: R3 R4 R5 R6 R7
        for (int v = 0; v < 13; v++) begin
            cfg_write(3'd4, {29'h0, VEC[v][50:48]});
            run_frame(VEC[v][47:0], 1'b0, $sformatf("R3-R7 vector %0d", v));
        end

        // R4: upper hash word and word select
        cfg_write(3'd4, 32'h0);
        g = 48'h01_00_5E_00_00_00;
        for (int k = 0; k < 256; k++) begin
            if (ref_idx(g)[5] == 1'b0) g[7:0] = g[7:0] + 8'd1;
        end
        gi = ref_idx(g);
        cfg_write(3'd2, 32'h0);
        cfg_write(3'd3, 32'h1 << gi[4:0]);
        run_frame(g, 1'b0, "R4 upper word hit");
        check(gi[5] == 1'b1, "R4 index search", gi[5], 1'b1);
        cfg_write(3'd3, 32'h0);
        cfg_write(3'd2, 32'h1 << gi[4:0]);
        run_frame(g, 1'b0, "R4 wrong word miss");

        // R2: stalled byte stream
        run_frame(STA, 1'b1, "R2 stalled unicast");

        // R8: restart mid-address
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = 8'hC3;
        end
        run_frame(STA, 1'b0, "R8 restart");

        // R8: trailing bytes give no decision
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rx_vld = 1'b1; rx_sof = 1'b0; rx_byte = STA[47 - 8*i -: 8];
            if (i > 0) check(dec_valid == 1'b0, "R8 trailing", dec_valid, 1'b0);
        end
        @(negedge clk);
        rx_vld = 1'b0;
        check(dec_valid == 1'b0, "R8 trailing end", dec_valid, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule